// File: doc/BRIEF.md
# High Address Region Decoder

This block sorts transaction addresses that lie above the 4 GB line into one of four destinations: the system memory port, a high MMIO peer port, the subtractive decode port, or an abort. It also marks each memory-bound result as coherent or non-coherent. Software sets the decode through a small write port. The values it writes are top of high memory, a non-coherent window, a local and a global high MMIO window, and a protected window. Every value is a 64 MB page number, which is the address with its low 26 bits dropped.

A request carries an address, a direction flag and a no-snoop attribute. It is accepted on a valid/ready handshake, and its result appears registered on the following cycle. The response is held until the consumer takes it. A register write takes effect only while no request is waiting and no response is pending. A status output reports when the global MMIO pair differs from the local pair.

Top module: `hiaddr_decoder`

## Requirements
- R1: A request accepted on a clock edge (reqValid and reqReady both high) produces rspValid high after that edge. While rspValid is high, rspTarget is one-hot with this encoding: bit 0 is system memory, bit 1 is the MMIO peer, bit 2 is subtractive decode, and bit 3 is abort.
- R2: High memory covers page numbers from 64 (the 4 GB line) up to topHigh − 1. The upper bound is exclusive. An inbound request in high memory that misses the protected window targets system memory.
- R3: An inbound request above 4 GB that hits the protected window targets abort with rspDecodeErr = 1. This takes priority over every other inbound route.
- R4: A system-memory result is coherent (rspCoherent = 1) unless its page lies inside the non-coherent window. rspCoherent is 0 for every other target.
- R5: A request with reqNoSnoop = 1 always returns rspCoherent = 0.
- R6: An outbound request in high memory is routed as subtractive, and rspDecodeErr stays 0.
- R7: A request above 4 GB that is outside high memory and inside the local MMIO window targets the peer port. This holds in both directions, and the window limit is inclusive.
- R8: A subtractive route goes to abort instead when subPresent = 0. rspDecodeErr stays 0 in that case.
- R9: A window whose limit is below its base matches no page.
- R10: cfgMismatch is 1 exactly when the global MMIO base or limit differs from the local one. Register select codes: 0 topHigh, 1 nc base, 2 nc limit, 3 local base, 4 local limit, 5 global base, 6 global limit, 7 protected base, 8 protected limit.
- R11: While rspValid is high and rspReady is low, reqReady is low and the response fields hold their values.
- R12: A register write has no effect while reqValid or rspValid is high.
- R13: A request below 4 GB (page below 64) is routed as subtractive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 4 | Register select code |
| cfgData | input | 38 | Page number to write |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request can be accepted |
| reqAddr | input | 64 | Request byte address |
| reqInbound | input | 1 | 1 = inbound, 0 = outbound |
| reqNoSnoop | input | 1 | No-snoop attribute |
| subPresent | input | 1 | A subtractive decode port exists |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Consumer takes the response |
| rspTarget | output | 4 | One-hot destination |
| rspCoherent | output | 1 | Coherent result |
| rspDecodeErr | output | 1 | Protected-range violation |
| cfgMismatch | output | 1 | Global MMIO pair differs from local pair |

## Verification
Three window layouts are used. Each is swept across page numbers 0 to 127 plus two very high pages, with every combination of direction, no-snoop and subtractive presence.

- The first layout nests the non-coherent and protected windows inside high memory and puts the MMIO window above it. This separates the priorities of protection, memory and MMIO, and the two directions.
- The second layout has no high memory and a mismatched global pair. It shows MMIO routing starting right at the 4 GB line, and the mismatch flag.
- The third layout fills the whole sweep with memory and uses inverted windows. This shows that disabled windows match nothing.

Separate sequences stall the response and attempt writes during a stall and during a request. They show that a write is ignored by whether a later page-70 request still reaches memory.

// File: rtl/hiaddr_pkg.sv
package hiaddr_pkg;
  typedef enum logic [3:0] {
    SEL_TOP       = 4'd0,
    SEL_NC_BASE   = 4'd1,
    SEL_NC_LIM    = 4'd2,
    SEL_LOC_BASE  = 4'd3,
    SEL_LOC_LIM   = 4'd4,
    SEL_GLB_BASE  = 4'd5,
    SEL_GLB_LIM   = 4'd6,
    SEL_PROT_BASE = 4'd7,
    SEL_PROT_LIM  = 4'd8
  } cfgSel_e;

  typedef struct packed {
    logic capture;
    logic cfgWrite;
  } strobe_t;

  localparam int TGT_MEM   = 0;
  localparam int TGT_PEER  = 1;
  localparam int TGT_SUB   = 2;
  localparam int TGT_ABORT = 3;
  localparam int TGT_W     = 4;

  localparam int WIN_NC   = 0;
  localparam int WIN_LOC  = 1;
  localparam int WIN_PROT = 2;
  localparam int NUM_WIN  = 3;
endpackage

// File: rtl/hiaddr_win.sv
module hiaddr_win #(
  parameter int PAGE_W = 38
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] base,
  input  logic [PAGE_W-1:0] limit,
  output logic              hit
);
  logic enabled;
  assign enabled = (limit >= base);
  assign hit = enabled && (page >= base) && (page <= limit);
endmodule

// File: rtl/hiaddr_ctrl.sv
module hiaddr_ctrl
  import hiaddr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    rspReady,
  input  logic    cfgWrEn,
  output logic    reqReady,
  output logic    rspValid,
  output strobe_t strobe
);
  assign reqReady        = !rspValid || rspReady;
  assign strobe.capture  = reqValid && reqReady;
  assign strobe.cfgWrite = cfgWrEn && !reqValid && !rspValid;

  always_ff @(posedge clk) begin
    if (!rstN)              rspValid <= 1'b0;
    else if (strobe.capture) rspValid <= 1'b1;
    else if (rspReady)       rspValid <= 1'b0;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> rspValid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);
  assert_cfg_gate_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cfgWrite |-> (!reqValid && !rspValid));
endmodule

// File: rtl/hiaddr_dp.sv
module hiaddr_dp
  import hiaddr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int GRAN_W = 26
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobe,
  input  logic [3:0]               cfgSel,
  input  logic [ADDR_W-GRAN_W-1:0] cfgData,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqInbound,
  input  logic                     reqNoSnoop,
  input  logic                     subPresent,
  output logic [TGT_W-1:0]         rspTarget,
  output logic                     rspCoherent,
  output logic                     rspDecodeErr,
  output logic                     cfgMismatch
);
  localparam int PAGE_W = ADDR_W - GRAN_W;
  localparam logic [PAGE_W-1:0] LOW_PAGES = PAGE_W'(1) << (32 - GRAN_W);

  logic [PAGE_W-1:0] topReg;
  logic [PAGE_W-1:0] glbBase, glbLim;
  logic [PAGE_W-1:0] winBase [NUM_WIN];
  logic [PAGE_W-1:0] winLim  [NUM_WIN];
  logic [NUM_WIN-1:0] winHit;
  logic [PAGE_W-1:0] page;

  assign page = reqAddr[ADDR_W-1:GRAN_W];

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      topReg  <= '0;
      glbBase <= '1;
      glbLim  <= '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        winBase[i] <= '1;
        winLim[i]  <= '0;
      end
    end else if (strobe.cfgWrite) begin
      case (cfgSel_e'(cfgSel))
        SEL_TOP:       topReg            <= cfgData;
        SEL_NC_BASE:   winBase[WIN_NC]   <= cfgData;
        SEL_NC_LIM:    winLim[WIN_NC]    <= cfgData;
        SEL_LOC_BASE:  winBase[WIN_LOC]  <= cfgData;
        SEL_LOC_LIM:   winLim[WIN_LOC]   <= cfgData;
        SEL_GLB_BASE:  glbBase           <= cfgData;
        SEL_GLB_LIM:   glbLim            <= cfgData;
        SEL_PROT_BASE: winBase[WIN_PROT] <= cfgData;
        SEL_PROT_LIM:  winLim[WIN_PROT]  <= cfgData;
        default: ;
      endcase
    end
  end

  assign cfgMismatch = (glbBase != winBase[WIN_LOC]) || (glbLim != winLim[WIN_LOC]);

  // window comparators
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    hiaddr_win #(.PAGE_W(PAGE_W)) win_i (
      .page (page),
      .base (winBase[w]),
      .limit(winLim[w]),
      .hit  (winHit[w])
    );
  end

  logic below4g, hiMem;
  assign below4g = page < LOW_PAGES;
  assign hiMem   = !below4g && (page < topReg);

  logic [TGT_W-1:0] tgtN;
  logic cohN, errN, subRoute;

  always_comb begin
    tgtN = '0;
    cohN = 1'b0;
    errN = 1'b0;
    subRoute = 1'b0;
    if (below4g) begin
      subRoute = 1'b1;
    end else if (reqInbound) begin
      if (winHit[WIN_PROT]) begin
        tgtN[TGT_ABORT] = 1'b1;
        errN = 1'b1;
      end else if (hiMem) begin
        tgtN[TGT_MEM] = 1'b1;
        cohN = !winHit[WIN_NC] && !reqNoSnoop;
      end else if (winHit[WIN_LOC]) begin
        tgtN[TGT_PEER] = 1'b1;
      end else begin
        subRoute = 1'b1;
      end
    end else begin
      if (hiMem)                subRoute = 1'b1;
      else if (winHit[WIN_LOC]) tgtN[TGT_PEER] = 1'b1;
      else                      subRoute = 1'b1;
    end
    if (subRoute) begin
      if (subPresent) tgtN[TGT_SUB]   = 1'b1;
      else            tgtN[TGT_ABORT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspTarget    <= '0;
      rspCoherent  <= 1'b0;
      rspDecodeErr <= 1'b0;
    end else if (strobe.capture) begin
      rspTarget    <= tgtN;
      rspCoherent  <= cohN;
      rspDecodeErr <= errN;
    end
  end

  assert_prot_abort_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && reqInbound && !below4g && winHit[WIN_PROT])
      |=> (rspTarget[TGT_ABORT] && rspDecodeErr));
  assert_coh_mem_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspCoherent |-> rspTarget[TGT_MEM]);
  assert_nosnoop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && reqNoSnoop) |=> !rspCoherent);
  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> $onehot(rspTarget));
  assert_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(rspTarget));
endmodule

// File: rtl/hiaddr_decoder.sv
module hiaddr_decoder
  import hiaddr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int GRAN_W = 26
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWrEn,
  input  logic [3:0]               cfgSel,
  input  logic [ADDR_W-GRAN_W-1:0] cfgData,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqInbound,
  input  logic                     reqNoSnoop,
  input  logic                     subPresent,
  output logic                     rspValid,
  input  logic                     rspReady,
  output logic [3:0]               rspTarget,
  output logic                     rspCoherent,
  output logic                     rspDecodeErr,
  output logic                     cfgMismatch
);
  strobe_t strobe;

  hiaddr_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .rspReady(rspReady),
    .cfgWrEn (cfgWrEn),
    .reqReady(reqReady),
    .rspValid(rspValid),
    .strobe  (strobe)
  );

  hiaddr_dp #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgSel      (cfgSel),
    .cfgData     (cfgData),
    .reqAddr     (reqAddr),
    .reqInbound  (reqInbound),
    .reqNoSnoop  (reqNoSnoop),
    .subPresent  (subPresent),
    .rspTarget   (rspTarget),
    .rspCoherent (rspCoherent),
    .rspDecodeErr(rspDecodeErr),
    .cfgMismatch (cfgMismatch)
  );
endmodule

// File: tb/hiaddr_decoder_tb_top.sv
`timescale 1ns/1ps
module hiaddr_decoder_tb_top;
  localparam int PW = 38;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [3:0] cfgSel = '0;
  logic [PW-1:0] cfgData = '0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [63:0] reqAddr = '0;
  logic reqInbound = 1'b0, reqNoSnoop = 1'b0, subPresent = 1'b1;
  logic rspValid;
  logic rspReady = 1'b1;
  logic [3:0] rspTarget;
  logic rspCoherent, rspDecodeErr, cfgMismatch;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hiaddr_decoder dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqInbound(reqInbound), .reqNoSnoop(reqNoSnoop), .subPresent(subPresent),
    .rspValid(rspValid), .rspReady(rspReady), .rspTarget(rspTarget),
    .rspCoherent(rspCoherent), .rspDecodeErr(rspDecodeErr), .cfgMismatch(cfgMismatch)
  );

  // bench copy of the programmed configuration
  logic [PW-1:0] cTop = '0, cNcB = '1, cNcL = '0, cLocB = '1, cLocL = '0, cPrB = '1, cPrL = '0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit inWin(logic [PW-1:0] pg, logic [PW-1:0] b, logic [PW-1:0] l);
    return (l >= b) && (pg >= b) && (pg <= l);
  endfunction

  // expected {err, coh, target[3:0]} from the requirements
  function automatic logic [5:0] model(logic [PW-1:0] pg, bit inb, bit ns, bit sub);
    logic [3:0] t = '0;
    bit c = 0, e = 0, sr = 0, hm;
    hm = (pg >= 64) && (pg < cTop);
    if (pg < 64) sr = 1;                                  // R13
    else if (inb) begin
      if (inWin(pg, cPrB, cPrL)) begin t = 4'b1000; e = 1; end   // R3
      else if (hm) begin t = 4'b0001; c = !inWin(pg, cNcB, cNcL) && !ns; end // R2 R4 R5
      else if (inWin(pg, cLocB, cLocL)) t = 4'b0010;        // R7
      else sr = 1;
    end else begin
      if (hm) sr = 1;                                       // R6
      else if (inWin(pg, cLocB, cLocL)) t = 4'b0010;
      else sr = 1;
    end
    if (sr) t = sub ? 4'b0100 : 4'b1000;                    // R8
    return {e, c, t};
  endfunction

  function automatic logic [PW-1:0] pageOf(int p);
    if (p == 128) return '1;
    if (p == 129) return PW'(1) << (PW - 1);
    return PW'(p);
  endfunction

  task automatic cfgWrite(int sel, logic [PW-1:0] val);
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 4'(sel); cfgData = val;
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0;
    case (sel)
      0: cTop = val; 1: cNcB = val; 2: cNcL = val; 3: cLocB = val; 4: cLocL = val;
      7: cPrB = val; 8: cPrL = val; default: ;
    endcase
  endtask

  task automatic doReq(logic [PW-1:0] pg, bit inb, bit ns, bit sub, string req);
    reqValid = 1'b1;
    reqAddr = {pg, 26'(pg[15:0] * 16'd40503 + 7)};
    reqInbound = inb; reqNoSnoop = ns; subPresent = sub;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    chk({req, " R1 valid"}, 64'(rspValid), 64'd1);
    chk(req, 64'({rspDecodeErr, rspCoherent, rspTarget}), 64'(model(pg, inb, ns, sub)));
  endtask

  task automatic sweep(string req);
    for (int p = 0; p < 130; p++)
      for (int k = 0; k < 8; k++)
        doReq(pageOf(p), k[0], k[1], k[2], req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset R1 rspValid", 64'(rspValid), 64'd0);
    chk("reset R11 reqReady", 64'(reqReady), 64'd1);
    chk("reset R10 mismatch", 64'(cfgMismatch), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    doReq(PW'(70), 1, 0, 1, "reset-config R9");
    doReq(PW'(70), 0, 0, 0, "reset-config R8");

    // layout A
    cfgWrite(0, PW'(96));
    cfgWrite(1, PW'(80)); cfgWrite(2, PW'(83));
    cfgWrite(3, PW'(100)); cfgWrite(4, PW'(109));
    cfgWrite(5, PW'(100));
    chk("R10 partial global pair", 64'(cfgMismatch), 64'd1);
    cfgWrite(6, PW'(109));
    chk("R10 equal pairs", 64'(cfgMismatch), 64'd0);
    cfgWrite(7, PW'(90)); cfgWrite(8, PW'(91));
    @(negedge clk);
    sweep("layoutA R2/R3/R4/R5/R6/R7/R8/R13");

    // R11 / R12: stall the response, then attempt a write
    @(negedge clk);
    rspReady = 1'b0;
    reqValid = 1'b1; reqAddr = {PW'(90), 26'd0}; reqInbound = 1; reqNoSnoop = 0; subPresent = 1;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    chk("R11 reqReady low", 64'(reqReady), 64'd0);
    chk("R3 abort held", 64'({rspDecodeErr, rspTarget}), 64'b11000);
    cfgWrEn = 1'b1; cfgSel = 4'd0; cfgData = PW'(64);
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0;
    chk("R11 rspValid held", 64'(rspValid), 64'd1);
    reqValid = 1'b1; reqAddr = {PW'(70), 26'd5}; reqInbound = 1;
    @(posedge clk); @(negedge clk);
    chk("R11 target held", 64'({rspDecodeErr, rspTarget}), 64'b11000);
    rspReady = 1'b1;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    chk("R12 write during stall ignored", 64'({rspValid, rspCoherent, rspTarget}), 64'b110001);
    @(posedge clk); @(negedge clk);
    chk("R1 response drained", 64'(rspValid), 64'd0);

    // R12: write in the same cycle as a request
    reqValid = 1'b1; reqAddr = {PW'(70), 26'd9}; reqInbound = 1;
    cfgWrEn = 1'b1; cfgSel = 4'd0; cfgData = PW'(64);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0; cfgWrEn = 1'b0;
    chk("R12 concurrent request", 64'(rspTarget), 64'b0001);
    @(negedge clk);
    doReq(PW'(70), 1, 0, 1, "R12 write with request ignored");

    // layout B: no high memory, MMIO at 4 GB, mismatched global
    cfgWrite(0, PW'(64));
    cfgWrite(1, PW'(5)); cfgWrite(2, PW'(2));
    cfgWrite(3, PW'(64)); cfgWrite(4, PW'(70));
    cfgWrite(7, PW'(120)); cfgWrite(8, PW'(127));
    chk("R10 mismatch set", 64'(cfgMismatch), 64'd1);
    @(negedge clk);
    sweep("layoutB R7/R9/R3");

    // layout C: memory everywhere in sweep, disabled windows
    cfgWrite(0, PW'(128));
    cfgWrite(1, PW'(64)); cfgWrite(2, PW'(64));
    cfgWrite(3, PW'(110)); cfgWrite(4, PW'(105));
    cfgWrite(5, PW'(110)); cfgWrite(6, PW'(105));
    cfgWrite(7, PW'(100)); cfgWrite(8, PW'(99));
    chk("R10 mismatch cleared", 64'(cfgMismatch), 64'd0);
    @(negedge clk);
    sweep("layoutC R9/R4/R2");

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule